// File: doc/BRIEF.md
# Fallback Boot Controller

This controller runs inside a factory configuration image and decides which of two application images the device loads next. Once it gets a start pulse, it samples a cause input. The cause is either a cold start or external reset, or a failed configuration attempt. It then reads two one-bit flags from serial flash through a byte-level command port. The page flag selects the primary application image. The retry flag is a persistent marker that limits fallback to one attempt.

On a cold start the controller clears the retry flag and launches the primary image. On the first configuration failure it sets the retry flag and launches the other image. On a second failure it issues no reconfiguration: it parks in the factory image with a halted output raised. Flash commands use a valid/done handshake. A command that waits too long for done sends the controller into a sticky error state. The reconfigure request is a one-cycle pulse that carries the 24-bit start address of the chosen image.

Top module: `fallback_boot_ctrl`

## Requirements
- R1: After reset the controller idles: stat_state is 0, and flash_cmd_valid, reconf_req, halted and error are all low. stat_image is 0.
- R2: A flash command stays on flash_cmd_valid with stable op and address until flash_done is seen. Op codes are read=0, write=1 and erase=2. The first command after start is a read of the page byte at address 0x780000.
- R3: When cause_fail is 0, the controller writes byte 0x00 to address 0x7C0000. It then requests image 1 (start 0x280000) if the page flag is 0, and image 2 (start 0x500000) if it is 1. This takes two flash commands in total.
- R4: When cause_fail is 1, the controller reads the retry byte at 0x7C0000. If the retry flag is 0, it issues an erase (op 2) at 0x7C0000, which leaves the byte at 0xFF. It then requests the image opposite to the page flag: image 2 for page 0, image 1 for page 1. This takes three flash commands.
- R5: When cause_fail is 1 and the retry flag is 1, no write or erase is issued and no reconfigure request is made. halted rises and stays high, and stat_state is 7.
- R6: Only bit 0 of the page byte and of the retry byte is used. The other bits have no effect on the chosen image or path.
- R7: reconf_req is high for exactly one cycle, and only after the last flash command has completed. In that cycle reconf_addr holds the start address of the chosen image. stat_image reports the requested image: 1, 2, or 0 for none.
- R8: If a command waits TIMEOUT_CYC cycles without flash_done, the controller enters error. In that state error stays high, flash_cmd_valid goes low, no reconfigure is made, and stat_state is 8.
- R9: start has no effect unless the controller is idle. After a launch (stat_state 6), a halt or an error, the controller stays put until reset.
- R10: stat_page reports bit 0 of the last page byte read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin the boot decision (idle only) |
| cause_fail | input | 1 | 1 = entered after configuration failure, 0 = cold start or external reset |
| flash_cmd_valid | output | 1 | Flash command pending |
| flash_cmd_op | output | 2 | 0 read byte, 1 write byte, 2 erase sector |
| flash_addr | output | ADDR_W | Flash byte or sector address |
| flash_wdata | output | DATA_W | Write data |
| flash_done | input | 1 | One-cycle completion of the pending command |
| flash_rdata | input | DATA_W | Read data, valid with flash_done |
| reconf_req | output | 1 | One-cycle reconfigure request |
| reconf_addr | output | ADDR_W | Start address of the requested image |
| halted | output | 1 | Stopped in the factory image after a second failure |
| error | output | 1 | Sticky flash timeout |
| stat_state | output | 4 | Current state code |
| stat_page | output | 1 | Last page flag read |
| stat_image | output | 2 | Requested image: 0 none, 1 image 1, 2 image 2 |

## Verification
The decision is tried with every combination of cause and both flag values. Together these separate the cold path, the first-fallback path and the halt path, and show which image each path selects for each page setting. Two extra patterns fill the unused bits of the flag bytes with ones while bit 0 stays clear. They catch a design that tests the whole byte instead of bit 0. A mute flash model exercises the timeout. Start pulses sent after a launch and after a halt show that the terminal states hold.

// File: rtl/fbc_pkg.sv
package fbc_pkg;
   typedef enum logic [3:0] {
      ST_IDLE      = 4'd0,
      ST_RD_PAGE   = 4'd1,
      ST_RD_RETRY  = 4'd2,
      ST_CLR_RETRY = 4'd3,
      ST_SET_RETRY = 4'd4,
      ST_LAUNCH    = 4'd5,
      ST_BOOTED    = 4'd6,
      ST_HALT      = 4'd7,
      ST_ERR       = 4'd8
   } fbc_state_e;

   typedef enum logic [1:0] {
      OP_READ  = 2'd0,
      OP_WRITE = 2'd1,
      OP_ERASE = 2'd2
   } fbc_op_e;

   typedef enum logic [1:0] {
      IMG_NONE = 2'd0,
      IMG_ONE  = 2'd1,
      IMG_TWO  = 2'd2
   } fbc_img_e;
endpackage

// File: rtl/fbc_addr_map.sv
module fbc_addr_map #(
   parameter int ADDR_W     = 24,
   parameter int SECT_LOG2  = 18,
   parameter int IMG1_SECT  = 10,
   parameter int IMG2_SECT  = 20,
   parameter int PAGE_SECT  = 30,
   parameter int RETRY_SECT = 31
) (
   input  fbc_pkg::fbc_img_e  img,
   output logic [ADDR_W-1:0]  img_addr,
   output logic [ADDR_W-1:0]  page_addr,
   output logic [ADDR_W-1:0]  retry_addr
);
   localparam logic [ADDR_W-1:0] IMG1_BASE  = ADDR_W'(IMG1_SECT  * (2 ** SECT_LOG2));
   localparam logic [ADDR_W-1:0] IMG2_BASE  = ADDR_W'(IMG2_SECT  * (2 ** SECT_LOG2));
   localparam logic [ADDR_W-1:0] PAGE_BASE  = ADDR_W'(PAGE_SECT  * (2 ** SECT_LOG2));
   localparam logic [ADDR_W-1:0] RETRY_BASE = ADDR_W'(RETRY_SECT * (2 ** SECT_LOG2));

   assign page_addr  = PAGE_BASE;
   assign retry_addr = RETRY_BASE;

   always_comb begin
      case (img)
         fbc_pkg::IMG_ONE: img_addr = IMG1_BASE;
         fbc_pkg::IMG_TWO: img_addr = IMG2_BASE;
         default:          img_addr = '0;
      endcase
   end
endmodule

// File: rtl/fbc_wait_timer.sv
module fbc_wait_timer #(
   parameter int LIMIT = 1000
) (
   input  logic clk,
   input  logic rst_n,
   input  logic waiting,
   input  logic done,
   output logic expired
);
   generate
      if (LIMIT == 0) begin : g_off
         logic unused_tmr;
         assign unused_tmr = clk ^ rst_n ^ waiting ^ done;
         assign expired = 1'b0;
      end else begin : g_on
         localparam int CW = $clog2(LIMIT + 1);
         localparam logic [CW-1:0] LAST = CW'(LIMIT - 1);
         logic [CW-1:0] cnt;
         always_ff @(posedge clk) begin
            if (!rst_n || !waiting || done) cnt <= '0;
            else if (cnt != LAST)          cnt <= cnt + 1'b1;
         end
         assign expired = waiting && !done && (cnt == LAST);
      end
   endgenerate
endmodule

// File: rtl/fallback_boot_ctrl.sv
module fallback_boot_ctrl
   import fbc_pkg::*;
#(
   parameter int ADDR_W      = 24,
   parameter int DATA_W      = 8,
   parameter int SECT_LOG2   = 18,
   parameter int IMG_SECTS   = 10,
   parameter int IMG1_SECT   = 10,
   parameter int IMG2_SECT   = 20,
   parameter int PAGE_SECT   = 30,
   parameter int RETRY_SECT  = 31,
   parameter int TIMEOUT_CYC = 1000
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic              cause_fail,
   output logic              flash_cmd_valid,
   output logic [1:0]        flash_cmd_op,
   output logic [ADDR_W-1:0] flash_addr,
   output logic [DATA_W-1:0] flash_wdata,
   input  logic              flash_done,
   input  logic [DATA_W-1:0] flash_rdata,
   output logic              reconf_req,
   output logic [ADDR_W-1:0] reconf_addr,
   output logic              halted,
   output logic              error,
   output logic [3:0]        stat_state,
   output logic              stat_page,
   output logic [1:0]        stat_image
);
   generate
      if (DATA_W < 1) begin : g_bad_dw
         $error("DATA_W must be at least 1");
      end
      if (IMG1_SECT + IMG_SECTS > IMG2_SECT || IMG2_SECT + IMG_SECTS > PAGE_SECT) begin : g_bad_map
         $error("image regions overlap");
      end
      if ((RETRY_SECT + 1) * (2 ** SECT_LOG2) > 2 ** ADDR_W) begin : g_bad_aw
         $error("flag sector exceeds address width");
      end
   endgenerate

   fbc_state_e        state;
   logic              cause_q;
   logic              page_q;
   fbc_img_e          img_q;
   logic              tmo;
   logic [ADDR_W-1:0] img_addr, page_addr, retry_addr;
   logic              unused_rdata_hi;

   assign unused_rdata_hi = ^flash_rdata;

   fbc_addr_map #(
      .ADDR_W(ADDR_W), .SECT_LOG2(SECT_LOG2), .IMG1_SECT(IMG1_SECT),
      .IMG2_SECT(IMG2_SECT), .PAGE_SECT(PAGE_SECT), .RETRY_SECT(RETRY_SECT)
   ) u_map (
      .img(img_q), .img_addr(img_addr), .page_addr(page_addr), .retry_addr(retry_addr)
   );

   fbc_wait_timer #(.LIMIT(TIMEOUT_CYC)) u_tmr (
      .clk(clk), .rst_n(rst_n), .waiting(flash_cmd_valid), .done(flash_done), .expired(tmo)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state   <= ST_IDLE;
         cause_q <= 1'b0;
         page_q  <= 1'b0;
         img_q   <= IMG_NONE;
      end else begin
         case (state)
            ST_IDLE: if (start) begin
               cause_q <= cause_fail;
               state   <= ST_RD_PAGE;
            end
            ST_RD_PAGE: if (flash_done) begin
               page_q <= flash_rdata[0];
               if (cause_q) state <= ST_RD_RETRY;
               else begin
                  img_q <= flash_rdata[0] ? IMG_TWO : IMG_ONE;
                  state <= ST_CLR_RETRY;
               end
            end else if (tmo) state <= ST_ERR;
            ST_RD_RETRY: if (flash_done) begin
               if (flash_rdata[0]) state <= ST_HALT;
               else begin
                  img_q <= page_q ? IMG_ONE : IMG_TWO;
                  state <= ST_SET_RETRY;
               end
            end else if (tmo) state <= ST_ERR;
            ST_CLR_RETRY, ST_SET_RETRY: if (flash_done) state <= ST_LAUNCH;
                                        else if (tmo)  state <= ST_ERR;
            ST_LAUNCH: state <= ST_BOOTED;
            default:   state <= state;
         endcase
      end
   end

   always_comb begin
      flash_cmd_valid = 1'b0;
      flash_cmd_op    = OP_READ;
      flash_addr      = '0;
      case (state)
         ST_RD_PAGE:   begin flash_cmd_valid = 1'b1; flash_addr = page_addr; end
         ST_RD_RETRY:  begin flash_cmd_valid = 1'b1; flash_addr = retry_addr; end
         ST_CLR_RETRY: begin flash_cmd_valid = 1'b1; flash_cmd_op = OP_WRITE; flash_addr = retry_addr; end
         ST_SET_RETRY: begin flash_cmd_valid = 1'b1; flash_cmd_op = OP_ERASE; flash_addr = retry_addr; end
         default: ;
      endcase
   end

   assign flash_wdata = '0;
   assign reconf_req  = (state == ST_LAUNCH);
   assign reconf_addr = img_addr;
   assign halted      = (state == ST_HALT);
   assign error       = (state == ST_ERR);
   assign stat_state  = state;
   assign stat_page   = page_q;
   assign stat_image  = img_q;
endmodule

// File: rtl/fbc_checker.sv
module fbc_checker (
   input logic       clk,
   input logic       rst_n,
   input logic       flash_cmd_valid,
   input logic       flash_done,
   input logic       reconf_req,
   input logic       halted,
   input logic       error,
   input logic [3:0] stat_state,
   input logic [1:0] stat_image
);
   a_r1_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      (stat_state == 4'd0) |-> (!flash_cmd_valid && !reconf_req));
   a_r2_hold_until_done: assert property (@(posedge clk) disable iff (!rst_n)
      (flash_cmd_valid && !flash_done) |=> (flash_cmd_valid || error));
   a_r5_halt_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      halted |=> halted);
   a_r7_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      reconf_req |=> !reconf_req);
   a_r7_after_flash: assert property (@(posedge clk) disable iff (!rst_n)
      reconf_req |-> !flash_cmd_valid);
   a_r7_image_named: assert property (@(posedge clk) disable iff (!rst_n)
      reconf_req |-> (stat_image == 2'd1 || stat_image == 2'd2));
   a_r8_error_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      error |=> (error && !flash_cmd_valid));
   a_r9_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({halted, error, reconf_req}));
endmodule

bind fallback_boot_ctrl fbc_checker u_chk (
   .clk(clk), .rst_n(rst_n), .flash_cmd_valid(flash_cmd_valid), .flash_done(flash_done),
   .reconf_req(reconf_req), .halted(halted), .error(error),
   .stat_state(stat_state), .stat_image(stat_image)
);

// File: tb/fallback_boot_ctrl_test.sv
module fallback_boot_ctrl_test;
   localparam int TMO = 40;
   localparam int LAT = 3;
   localparam logic [23:0] PAGE_A  = 24'h780000;
   localparam logic [23:0] RETRY_A = 24'h7C0000;
   localparam logic [23:0] IMG1_A  = 24'h280000;
   localparam logic [23:0] IMG2_A  = 24'h500000;

   logic clk = 0, rst_n = 0, start = 0, cause_fail = 0;
   logic flash_cmd_valid, flash_done = 0, reconf_req, halted, error, stat_page;
   logic [1:0] flash_cmd_op, stat_image;
   logic [23:0] flash_addr, reconf_addr;
   logic [7:0] flash_wdata, flash_rdata = 0;
   logic [3:0] stat_state;

   always #10 clk = ~clk;

   fallback_boot_ctrl #(.TIMEOUT_CYC(TMO)) uut (
      .clk(clk), .rst_n(rst_n), .start(start), .cause_fail(cause_fail),
      .flash_cmd_valid(flash_cmd_valid), .flash_cmd_op(flash_cmd_op), .flash_addr(flash_addr),
      .flash_wdata(flash_wdata), .flash_done(flash_done), .flash_rdata(flash_rdata),
      .reconf_req(reconf_req), .reconf_addr(reconf_addr), .halted(halted), .error(error),
      .stat_state(stat_state), .stat_page(stat_page), .stat_image(stat_image)
   );

   int checks = 0, fails = 0;
   logic [7:0] init_page = 0, init_retry = 0, page_b, retry_b;
   logic mute = 0;
   int f_cnt, ncmd, reconf_cnt;
   logic [1:0] first_op, last_op;
   logic [23:0] first_addr, last_addr, seen_addr;

   always @(posedge clk) begin
      if (!rst_n) begin
         flash_done <= 0; f_cnt <= 0; ncmd <= 0;
         page_b <= init_page; retry_b <= init_retry;
         first_op <= 0; last_op <= 0; first_addr <= 0; last_addr <= 0;
      end else begin
         flash_done <= 0;
         if (flash_cmd_valid && !flash_done && !mute) begin
            if (f_cnt == LAT) begin
               flash_done  <= 1; f_cnt <= 0;
               flash_rdata <= (flash_addr == RETRY_A) ? retry_b : page_b;
               ncmd <= ncmd + 1;
               last_op <= flash_cmd_op; last_addr <= flash_addr;
               if (ncmd == 0) begin first_op <= flash_cmd_op; first_addr <= flash_addr; end
               if (flash_cmd_op == 2'd1 && flash_addr == RETRY_A) retry_b <= flash_wdata;
               if (flash_cmd_op == 2'd2 && flash_addr == RETRY_A) retry_b <= 8'hFF;
            end else f_cnt <= f_cnt + 1;
         end
      end
   end

   always @(posedge clk) begin
      if (!rst_n) begin reconf_cnt <= 0; seen_addr <= 0; end
      else if (reconf_req) begin reconf_cnt <= reconf_cnt + 1; seen_addr <= reconf_addr; end
   end

   int cyc = 0;
   always @(posedge clk) begin
      cyc <= cyc + 1;
      if (cyc > 100000) begin
         fails = fails + 1;
         $display("FAIL watchdog: run did not finish (actual %0d cycles, expected < 100000)", cyc);
         $display("End of test - %0d assertions evaluated, %0d failures", checks + 1, fails);
         $finish;
      end
   end

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   task automatic do_reset();
      @(negedge clk); rst_n = 0;
      repeat (3) @(negedge clk);
      rst_n = 1;
      @(negedge clk);
   endtask

   task automatic kick(input logic c);
      cause_fail = c; start = 1;
      @(negedge clk); start = 0;
      for (int i = 0; i < 300 && !(halted || error || stat_state == 4'd6); i++) @(negedge clk);
      repeat (3) @(negedge clk);
   endtask

   // {cause, page byte, retry byte, image, halt, retry after, commands}
   localparam logic [31:0] VEC [8] = '{
      {1'b0, 8'h00, 8'h01, 2'd1, 1'b0, 8'h00, 4'd2},
      {1'b0, 8'h01, 8'h00, 2'd2, 1'b0, 8'h00, 4'd2},
      {1'b1, 8'h00, 8'h00, 2'd2, 1'b0, 8'hFF, 4'd3},
      {1'b1, 8'h01, 8'h00, 2'd1, 1'b0, 8'hFF, 4'd3},
      {1'b1, 8'h00, 8'h01, 2'd0, 1'b1, 8'h01, 4'd2},
      {1'b1, 8'h01, 8'h01, 2'd0, 1'b1, 8'h01, 4'd2},
      {1'b0, 8'hFE, 8'hFF, 2'd1, 1'b0, 8'h00, 4'd2},
      {1'b1, 8'hFF, 8'hFE, 2'd1, 1'b0, 8'hFF, 4'd3}
   };

   initial begin
      do_reset();
      // R1 reset state
      chk("R1 state", stat_state, 0);
      chk("R1 outputs", {flash_cmd_valid, reconf_req, halted, error}, 0);
      chk("R1 image", stat_image, 0);

      for (int v = 0; v < 8; v++) begin
         logic c, h; logic [7:0] p, r, er; logic [1:0] im; logic [3:0] n;
         {c, p, r, im, h, er, n} = VEC[v];
         init_page = p; init_retry = r;
         do_reset();
         kick(c);
         chk("R2 first op read", first_op, 0);
         chk("R2 first addr page", first_addr, PAGE_A);
         chk(c ? "R4/R5 command count" : "R3 command count", ncmd, n);
         chk(c ? "R4/R5 retry byte" : "R3 retry byte", retry_b, er);
         chk("R10 page flag", stat_page, p[0]);
         chk("R7 image status", stat_image, im);
         if (h) begin
            chk("R5 halted", {halted, stat_state}, {1'b1, 4'd7});
            chk("R5 no reconfig", reconf_cnt, 0);
         end else begin
            chk(c ? "R4 last op erase" : "R3 last op write", last_op, c ? 2 : 1);
            chk("R7 one request", reconf_cnt, 1);
            chk("R7 request addr", seen_addr, (im == 2'd1) ? IMG1_A : IMG2_A);
            chk("R6 LSB decides", stat_state, 6);
         end
         if (v == 1 || v == 4) begin
            // R9 start ignored in terminal states
            kick(~c);
            repeat (20) @(negedge clk);
            chk("R9 no new commands", ncmd, n);
            chk("R9 state held", stat_state, h ? 7 : 6);
            chk("R9 no new request", reconf_cnt, h ? 0 : 1);
         end
      end

      // R8 timeout
      mute = 1; init_page = 0; init_retry = 0;
      do_reset();
      cause_fail = 0; start = 1; @(negedge clk); start = 0;
      repeat (TMO - 5) @(negedge clk);
      chk("R8 no early error", error, 0);
      chk("R2 valid held", flash_cmd_valid, 1);
      repeat (20) @(negedge clk);
      chk("R8 error", {error, stat_state}, {1'b1, 4'd8});
      chk("R8 valid dropped", flash_cmd_valid, 0);
      mute = 0;
      repeat (20) @(negedge clk);
      chk("R8 sticky", error, 1);
      chk("R8 no reconfig", reconf_cnt, 0);

      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end
endmodule